// File: doc/BRIEF.md
# Extended-to-Double Floating-Point Format Converter

This block converts floating-point values in either direction between the 80-bit extended memory layout and the 64-bit double layout. An 80-bit value keeps a 64-bit significand with an explicit integer bit in bits 63:0, and a sign-and-exponent word in bits 79:64. In that word, bit 79 is the sign and bits 78:64 are the biased exponent, with a bias of 16383. A double has the sign in bit 63, an 11-bit exponent with a bias of 1023 in bits 62:52, and a 52-bit fraction in bits 51:0. Going from extended to double, the block re-biases the exponent, drops the integer bit and rounds on the first discarded significand bit. Going from double to extended, it restores the integer bit and re-biases the exponent the other way.

Operands enter on a valid/ready stream and results leave on one. A word moves only on a clock edge where its valid and ready are both high. The output stage holds one result. The input is ready whenever that stage is empty, or when its current result is being taken on the same edge. While the consumer holds `out_ready` low with a result waiting, the block stalls the producer and holds the result unchanged. A one-bit inexact flag travels with every result.

Top module: `fpx_fmt_conv`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` and `out_inexact` are 0, and `in_ready` is 1. An operand accepted on an edge appears with `out_valid` high after that edge, a single cycle of latency.
- R2: While `out_valid` is high and `out_ready` is low, `in_ready` is 0, and `out_data` and `out_inexact` stay unchanged.
- R3: With `in_dir`=0 (extended to double) and a normal in-range operand, the result is built as follows:
  - bit 63 takes the sign;
  - bits 62:52 take the exponent minus 15360;
  - bits 51:0 take significand bits 62:11, plus 1 when significand bit 10 is set;
  - `out_data[79:64]` is 0.
- R4: In the extended-to-double direction, when the rounding increment carries out of an all-ones fraction, the fraction becomes 0 and the exponent rises by one.
- R5: In the extended-to-double direction, for a normal in-range result, `out_inexact` is 1 exactly when significand bits 10:0 are not all zero.
- R6: In the extended-to-double direction, an operand whose exponent is 0, or whose integer bit (significand bit 63) is clear with a non-all-ones exponent, gives a zero with the operand's sign. `out_inexact` is then 1 exactly when the significand is nonzero.
- R7: In the extended-to-double direction, an operand with an all-ones exponent gives an all-ones double exponent with inexact 0:
  - if significand bits 62:0 are zero, the fraction is 0 (infinity);
  - otherwise the fraction is significand bits 62:11, or 1 when those bits are all zero, so a NaN stays a NaN.
- R8: In the extended-to-double direction, when the re-biased exponent (after any rounding carry) is 2047 or more, the result is an infinity with the operand's sign and inexact 1.
- R9: In the extended-to-double direction, when the re-biased exponent is 0 or less, the result is a zero with the operand's sign and inexact 1.
- R10: With `in_dir`=1 (double to extended), the double is taken from `in_data[63:0]` and `in_data[79:64]` is ignored. For a normal double, the result is built as follows, with inexact 0:
  - the sign is kept;
  - the exponent becomes the double exponent plus 15360;
  - significand bit 63 is 1;
  - significand bits 62:11 hold the fraction;
  - significand bits 10:0 are 0.
- R11: In the double-to-extended direction, a double with exponent 0 gives a zero with its sign. `out_inexact` is 1 exactly when the fraction is nonzero.
- R12: In the double-to-extended direction, a double with an all-ones exponent gives exponent 0x7FFF, significand bit 63 set, the fraction in bits 62:11 and inexact 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this edge |
| in_dir | input | 1 | 0: extended to double, 1: double to extended |
| in_data | input | 80 | Operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this edge |
| out_data | output | 80 | Result, double in bits 63:0 when converting to double |
| out_inexact | output | 1 | Discarded significand bits were nonzero |

## Verification
The only state inside the block is the one-entry output register and its valid bit, so a wrong internal state shows up on the very next sampled cycle. It appears as a lost or duplicated result, a result that changes while it is stalled, or `in_ready` held high while a result waits. The conversion paths are combinational in front of that register, so an error in re-biasing, rounding carry or special-case selection shows up in the result of the same operand, one cycle after it is accepted. Random operands are aimed at the window around the double's exponent limits and at fractions that are all ones, so that overflow, underflow and rounding carry are each reached.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  typedef enum logic {
    DIR_X2D = 1'b0,
    DIR_D2X = 1'b1
  } conv_dir_e;

  function automatic int bias_of(input int ew);
    return (1 << (ew - 1)) - 1;
  endfunction
endpackage

// File: rtl/fpx_x2d.sv
module fpx_x2d #(
  parameter int XEW = 15,
  parameter int XMW = 64,
  parameter int DEW = 11,
  parameter int DFW = 52
) (
  input  logic [XEW+XMW:0]   x_in,
  output logic [DEW+DFW:0]   d_out,
  output logic               inexact
);
  localparam int SHIFT = XMW - 1 - DFW;
  localparam int BDIFF = fpx_pkg::bias_of(XEW) - fpx_pkg::bias_of(DEW);
  localparam int EW2   = XEW + 3;
  localparam int DEMAX = (1 << DEW) - 1;

  logic             sgn;
  logic [XEW-1:0]   xe;
  logic [XMW-1:0]   sig;
  logic [DFW-1:0]   frac_t;
  logic [DFW:0]     rsum;
  logic [EW2-1:0]   de_w;
  logic             de_neg, de_zero, de_big;
  logic [DEW-1:0]   o_exp;
  logic [DFW-1:0]   o_frac;

  assign sgn = x_in[XEW+XMW];
  assign xe  = x_in[XMW +: XEW];
  assign sig = x_in[XMW-1:0];

  always_comb begin
    frac_t  = sig[XMW-2 -: DFW];
    rsum    = {1'b0, frac_t} + (DFW+1)'(sig[SHIFT-1]);
    de_w    = EW2'(xe) - EW2'(BDIFF) + EW2'(rsum[DFW]);
    de_neg  = de_w[EW2-1];
    de_zero = (de_w == '0);
    de_big  = !de_neg && (de_w >= EW2'(DEMAX));
    o_exp   = '0;
    o_frac  = '0;
    inexact = 1'b0;
    if (&xe) begin
      o_exp = '1;
      if (sig[XMW-2:0] != '0)
        o_frac = (frac_t == '0) ? DFW'(1) : frac_t;
    end else if (xe == '0 || !sig[XMW-1]) begin
      inexact = (sig != '0);
    end else if (de_big) begin
      o_exp   = '1;
      inexact = 1'b1;
    end else if (de_neg || de_zero) begin
      inexact = 1'b1;
    end else begin
      o_exp   = de_w[DEW-1:0];
      o_frac  = rsum[DFW-1:0];
      inexact = |sig[SHIFT-1:0];
    end
    d_out = {sgn, o_exp, o_frac};
  end

  always_comb begin
    AST_SPECIAL_EXP: assert (!(&xe) || (&o_exp)); // R7
    AST_NAN_KEPT: assert (!((&xe) && sig[XMW-2:0] != '0) || o_frac != '0); // R7
    AST_SIGN_KEPT: assert (d_out[DEW+DFW] == sgn); // R3
  end
endmodule

// File: rtl/fpx_d2x.sv
module fpx_d2x #(
  parameter int XEW = 15,
  parameter int XMW = 64,
  parameter int DEW = 11,
  parameter int DFW = 52
) (
  input  logic [DEW+DFW:0]   d_in,
  output logic [XEW+XMW:0]   x_out,
  output logic               inexact
);
  localparam int SHIFT = XMW - 1 - DFW;
  localparam int BDIFF = fpx_pkg::bias_of(XEW) - fpx_pkg::bias_of(DEW);

  logic             sgn;
  logic [DEW-1:0]   de;
  logic [DFW-1:0]   fr;
  logic [XEW-1:0]   o_exp;
  logic [XMW-1:0]   o_sig;

  assign sgn = d_in[DEW+DFW];
  assign de  = d_in[DFW +: DEW];
  assign fr  = d_in[DFW-1:0];

  always_comb begin
    o_exp   = '0;
    o_sig   = '0;
    inexact = 1'b0;
    if (de == '0) begin
      inexact = (fr != '0);
    end else begin
      o_exp = (&de) ? '1 : (XEW'(de) + XEW'(BDIFF));
      o_sig = {1'b1, fr, {SHIFT{1'b0}}};
    end
    x_out = {sgn, o_exp, o_sig};
  end

  always_comb begin
    AST_INT_BIT: assert (de == '0 || o_sig[XMW-1]); // R10
    AST_LOW_CLEAR: assert (o_sig[SHIFT-1:0] == '0); // R10
  end
endmodule

// File: rtl/fpx_out_stage.sv
module fpx_out_stage #(
  parameter int W = 81
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_word  <= in_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R2
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R2
endmodule

// File: rtl/fpx_fmt_conv.sv
module fpx_fmt_conv #(
  parameter int XEW = 15,
  parameter int XMW = 64,
  parameter int DEW = 11,
  parameter int DFW = 52
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_dir,
  input  logic [XEW+XMW:0]     in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [XEW+XMW:0]     out_data,
  output logic                 out_inexact
);
  import fpx_pkg::*;

  localparam int XW = XEW + 1 + XMW;
  localparam int DW = DEW + 1 + DFW;

  conv_dir_e        dir;
  logic [DW-1:0]    x2d_res;
  logic             x2d_ix;
  logic [XW-1:0]    d2x_res;
  logic             d2x_ix;
  logic [XW:0]      nxt_word;
  logic [XW:0]      reg_word;

  assign dir = conv_dir_e'(in_dir);

  fpx_x2d #(.XEW(XEW), .XMW(XMW), .DEW(DEW), .DFW(DFW)) u_x2d (
    .x_in    (in_data),
    .d_out   (x2d_res),
    .inexact (x2d_ix)
  );

  fpx_d2x #(.XEW(XEW), .XMW(XMW), .DEW(DEW), .DFW(DFW)) u_d2x (
    .d_in    (in_data[DW-1:0]),
    .x_out   (d2x_res),
    .inexact (d2x_ix)
  );

  always_comb begin
    if (dir == DIR_X2D) nxt_word = {x2d_ix, {(XW-DW){1'b0}}, x2d_res};
    else                nxt_word = {d2x_ix, d2x_res};
  end

  fpx_out_stage #(.W(XW + 1)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (nxt_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (reg_word)
  );

  assign out_inexact = reg_word[XW];
  assign out_data    = reg_word[XW-1:0];
endmodule

// File: tb/fpx_fmt_conv_tb.sv
`timescale 1ns/1ps
module fpx_fmt_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_dir = 1'b0;
  logic [79:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [79:0] out_data;
  logic        out_inexact;
  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  fpx_fmt_conv u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dir(in_dir), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_inexact(out_inexact)
  );

  function automatic logic [80:0] ref_x2d(input logic [79:0] x);
    logic s; int e; logic [63:0] m; logic [51:0] f; int c; int ne; logic ix;
    s = x[79]; e = int'(x[78:64]); m = x[63:0];
    if (e == 32767) begin
      f = (m[62:0] == 0) ? 52'd0 : ((m[62:11] == 0) ? 52'd1 : m[62:11]);
      return {1'b0, 16'h0, s, 11'h7ff, f};
    end
    if (e == 0 || !m[63]) return {(m != 0), 16'h0, s, 63'h0};
    f = m[62:11]; c = 0;
    if (m[10]) begin
      if (&f) begin f = '0; c = 1; end
      else f = f + 52'd1;
    end
    ne = e - 15360 + c;
    if (ne >= 2047) return {1'b1, 16'h0, s, 11'h7ff, 52'h0};
    if (ne <= 0) return {1'b1, 16'h0, s, 63'h0};
    ix = (m[10:0] != 0);
    return {ix, 16'h0, s, 11'(ne), f};
  endfunction

  function automatic logic [80:0] ref_d2x(input logic [63:0] d);
    logic s; int de; logic [51:0] f;
    s = d[63]; de = int'(d[62:52]); f = d[51:0];
    if (de == 0) return {(f != 0), s, 79'h0};
    if (de == 2047) return {1'b0, s, 15'h7fff, 1'b1, f, 11'h0};
    return {1'b0, s, 15'(de + 15360), 1'b1, f, 11'h0};
  endfunction

  task automatic check(input string req, input logic [80:0] act, input logic [80:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic conv(input string req, input logic dir, input logic [79:0] v);
    logic [80:0] e;
    e = dir ? ref_d2x(v[63:0]) : ref_x2d(v);
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_data = v;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R1 valid"}, {80'h0, out_valid}, 81'h1);
    check(req, {out_inexact, out_data}, e);
  endtask

  function automatic logic [79:0] rnd_x();
    logic [14:0] e; logic [63:0] m;
    m = {$urandom, $urandom};
    case ($urandom % 5)
      0: e = 15'($urandom);
      1: e = 15'(15300 + ($urandom % 2170));
      2: e = 15'(17400 + ($urandom % 12));
      3: begin e = 15'(15357 + ($urandom % 6)); end
      default: begin e = 15'(15361 + ($urandom % 2040)); m[62:10] = '1; end
    endcase
    if (($urandom % 8) != 0) m[63] = 1'b1;
    if (($urandom % 16) == 0) e = 15'h7fff;
    return {1'($urandom), e, m};
  endfunction

  initial begin
    #(20ns * 150000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 reset", {out_valid, in_ready, out_inexact, out_data[77:0]}, {2'b01, 79'h0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", {79'h0, out_valid, in_ready}, 81'h1);

    conv("R3 one", 1'b0, {16'h3fff, 64'h8000_0000_0000_0000});
    conv("R3 neg", 1'b0, {16'hc000, 64'hc000_0000_0000_0000});
    conv("R5 inexact", 1'b0, {16'h3fff, 64'h8000_0000_0000_0001});
    conv("R4 carry", 1'b0, {16'h3fff, 64'hffff_ffff_ffff_fc00});
    conv("R8 carry overflow", 1'b0, {16'h43fe, 64'hffff_ffff_ffff_fc00});
    conv("R8 overflow", 1'b0, {16'hc7ff, 64'h8000_0000_0000_0000});
    conv("R9 underflow", 1'b0, {16'h3c00, 64'h8000_0000_0000_0000});
    conv("R9 edge", 1'b0, {16'hbc01, 64'h8000_0000_0000_0000});
    conv("R6 zero", 1'b0, {16'h8000, 64'h0});
    conv("R6 denorm", 1'b0, {16'h0000, 64'h0000_0000_0000_0100});
    conv("R6 unnormal", 1'b0, {16'h4000, 64'h4000_0000_0000_0000});
    conv("R7 inf", 1'b0, {16'hffff, 64'h8000_0000_0000_0000});
    conv("R7 nan low", 1'b0, {16'h7fff, 64'h8000_0000_0000_0001});
    conv("R7 nan", 1'b0, {16'h7fff, 64'hc000_0000_0000_0000});
    conv("R10 one", 1'b1, {16'hffff, 64'h3ff0_0000_0000_0000});
    conv("R10 max", 1'b1, {16'h1234, 64'hffef_ffff_ffff_ffff});
    conv("R11 zero", 1'b1, {16'h0, 64'h8000_0000_0000_0000});
    conv("R11 denorm", 1'b1, {16'h0, 64'h0000_0000_0000_0005});
    conv("R12 inf", 1'b1, {16'h0, 64'h7ff0_0000_0000_0000});
    conv("R12 nan", 1'b1, {16'h0, 64'hfff8_0000_0000_0001});

    for (int i = 0; i < 300; i++) conv("R3 random x2d", 1'b0, rnd_x());
    for (int i = 0; i < 200; i++) conv("R10 random d2x", 1'b1, {$urandom, $urandom, 16'($urandom)});

    // R2 back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_dir = 1'b0;
    in_data = {16'h3fff, 64'h8000_0000_0000_0000};
    @(negedge clk);
    in_dir = 1'b1; in_data = {16'h0, 64'h4000_0000_0000_0000};
    for (int k = 0; k < 3; k++) begin
      check("R2 stall ready", {80'h0, in_ready}, 81'h0);
      check("R2 hold", {out_valid, out_inexact, out_data},
            {1'b1, ref_x2d({16'h3fff, 64'h8000_0000_0000_0000})});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 next", {out_inexact, out_data}, ref_d2x(64'h4000_0000_0000_0000));
    check("R1 valid after release", {80'h0, out_valid}, 81'h1);
    @(negedge clk);
    check("R1 drained", {80'h0, out_valid}, 81'h0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule